// File: doc/BRIEF.md
# Area Chip-Select Generator

This block sits beside an external bus controller. It turns the address of each bus access into one of eight address areas. For the area that an external access falls in, it drives that area's active-low select line. The area number is the top three bits of a 24-bit address, so each area covers 2 MB.

Area 7 contains two internal windows, each set by a base and size parameter. The register window is always internal and never raises a select. The RAM window is internal while the RAM enable input is 1. While that input is 0, the RAM window is external space like the rest of area 7.

Each select pin has a direction bit that acts as its output enable. The reset value of the direction bits depends on the operating mode. Areas 2 to 5 each have a DRAM flag. When an area's flag is set, its select also appears on a dedicated row-strobe output. Both the direction bits and the DRAM flags are written through a simple write port.

Top module: `area_chip_select`

## Requirements
- R1: The area index is `addr[23:21]`. One clock edge after an external access (`acc_valid`=1) is presented, `cs_n[k]` is low for that area k and every other select is high. This holds for the lowest, second-lowest and highest address of every area.
- R2: One clock edge after a cycle with `acc_valid`=0, all eight selects are high.
- R3: At most one bit of `cs_n` is low at any time.
- R4: An access in the register window (24'hFFFF00 to 24'hFFFFFF) leaves all selects high, whatever the value of `ram_en`.
- R5: With `ram_en`=1, an access in the RAM window (24'hFFB000 to 24'hFFEFFF) leaves all selects high. With `ram_en`=0, it drives `cs_n[7]` low. Addresses just outside that window always drive `cs_n[7]` low.
- R6: `cs_oe` shows the eight direction bits. When reset is applied with `mode_rom_en`=0, they reset to 8'h01.
- R7: When reset is applied with `mode_rom_en`=1, the direction bits reset to 8'h00.
- R8: A write with `cfg_we`=1 and `cfg_sel`=0 loads `cfg_wdata` into the direction bits. The new value is seen on `cs_oe` after that clock edge.
- R9: A write with `cfg_we`=1 and `cfg_sel`=1 loads `cfg_wdata[3:0]` into the DRAM flags, with bit j standing for area 2+j. This write leaves `cs_oe` unchanged.
- R10: `ras_n[j]` is low exactly when `cs_n[2+j]` is low and DRAM flag j is set. Otherwise it is high. The DRAM flags reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rom_en | input | 1 | Operating mode: 1 = on-chip ROM enabled, 0 = disabled; sets the direction reset values |
| ram_en | input | 1 | On-chip RAM enable; 1 makes the RAM window internal |
| addr | input | 24 | Bus address of the current access |
| acc_valid | input | 1 | Access strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | Write target: 0 = direction bits, 1 = DRAM flags |
| cfg_wdata | input | 8 | Configuration write data |
| cs_n | output | 8 | Active-low area selects, registered |
| cs_oe | output | 8 | Per-pin output enables (direction bits) |
| ras_n | output | 4 | Active-low row strobes for areas 2 to 5 |

## Verification
The bench builds the block with its default parameters. These are a 24-bit address, eight areas, DRAM-capable areas 2 to 5, a 16 KB RAM window at 24'hFFB000 and a 256-byte register window at 24'hFFFF00. With only eight areas and two small windows, every area's lower and upper edge and every window edge can be swept. The sweep runs in both operating modes and with both RAM-enable settings. The expected select pattern is computed arithmetically from the address. Alternating DRAM flag patterns then show that each row strobe follows only its own area.

// File: rtl/acs_pkg.sv
package acs_pkg;

  typedef enum logic {
    CFG_DIR  = 1'b0,
    CFG_DRAM = 1'b1
  } cfg_target_e;

  // True when a lies in [base, base+size).
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [31:0] size);
    return (a >= base) && ((a - base) < size);
  endfunction

  // Direction reset pattern: select 0 starts driven only when ROM is off.
  function automatic logic [31:0] dir_reset_val(input logic rom_on);
    return rom_on ? 32'h0 : 32'h1;
  endfunction

endpackage

// File: rtl/acs_area_decode.sv
module acs_area_decode
  import acs_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          AREA_BITS = 3,
  parameter logic [31:0] RAM_BASE  = 32'hFFB000,
  parameter logic [31:0] RAM_SIZE  = 32'h4000,
  parameter logic [31:0] IO_BASE   = 32'hFFFF00,
  parameter logic [31:0] IO_SIZE   = 32'h100,
  localparam int         N_AREAS   = 1 << AREA_BITS
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 ram_en,
  output logic [AREA_BITS-1:0] area_idx,
  output logic                 int_hit,
  output logic [N_AREAS-1:0]   area_onehot
);

  localparam logic [AREA_BITS-1:0] TOP_AREA = AREA_BITS'(N_AREAS - 1);

  logic in_ram_win;
  logic in_io_win;

  assign area_idx   = addr[ADDR_W-1 -: AREA_BITS];
  assign in_ram_win = in_window(32'(addr), RAM_BASE, RAM_SIZE);
  assign in_io_win  = in_window(32'(addr), IO_BASE, IO_SIZE);

  // Internal windows only exist inside the topmost area.
  assign int_hit = (area_idx == TOP_AREA) && (in_io_win || (ram_en && in_ram_win));

  for (genvar g = 0; g < N_AREAS; g++) begin : g_onehot
    assign area_onehot[g] = (area_idx == AREA_BITS'(g));
  end

endmodule

// File: rtl/acs_cfg_regs.sv
module acs_cfg_regs
  import acs_pkg::*;
#(
  parameter int N_AREAS = 8,
  parameter int N_DRAM  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_rom_en,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [N_AREAS-1:0] cfg_wdata,
  output logic [N_AREAS-1:0] dir_q,
  output logic [N_DRAM-1:0]  dram_q
);

  logic dir_wr;
  logic dram_wr;

  assign dir_wr  = cfg_we && (cfg_target_e'(cfg_sel) == CFG_DIR);
  assign dram_wr = cfg_we && (cfg_target_e'(cfg_sel) == CFG_DRAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= N_AREAS'(dir_reset_val(mode_rom_en));
    end else if (dir_wr) begin
      dir_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_q <= '0;
    end else if (dram_wr) begin
      dram_q <= cfg_wdata[N_DRAM-1:0];
    end
  end

endmodule

// File: rtl/acs_select_out.sv
module acs_select_out #(
  parameter int N_AREAS = 8,
  parameter int DRAM_LO = 2,
  parameter int N_DRAM  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               int_hit,
  input  logic [N_AREAS-1:0] area_onehot,
  input  logic [N_DRAM-1:0]  dram_q,
  output logic [N_AREAS-1:0] cs_n,
  output logic [N_DRAM-1:0]  ras_n
);

  logic [N_AREAS-1:0] sel_d;
  logic [N_AREAS-1:0] sel_q;

  assign sel_d = (acc_valid && !int_hit) ? area_onehot : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign cs_n = ~sel_q;

  for (genvar j = 0; j < N_DRAM; j++) begin : g_ras
    assign ras_n[j] = ~(sel_q[DRAM_LO + j] & dram_q[j]);
  end

endmodule

// File: rtl/area_chip_select.sv
module area_chip_select #(
  parameter int          ADDR_W    = 24,
  parameter int          AREA_BITS = 3,
  parameter int          DRAM_LO   = 2,
  parameter int          DRAM_HI   = 5,
  parameter logic [31:0] RAM_BASE  = 32'hFFB000,
  parameter logic [31:0] RAM_SIZE  = 32'h4000,
  parameter logic [31:0] IO_BASE   = 32'hFFFF00,
  parameter logic [31:0] IO_SIZE   = 32'h100,
  localparam int         N_AREAS   = 1 << AREA_BITS,
  localparam int         N_DRAM    = DRAM_HI - DRAM_LO + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_rom_en,
  input  logic               ram_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               acc_valid,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [N_AREAS-1:0] cfg_wdata,
  output logic [N_AREAS-1:0] cs_n,
  output logic [N_AREAS-1:0] cs_oe,
  output logic [N_DRAM-1:0]  ras_n
);

  // Named internal events, observed by the checker.
  logic [AREA_BITS-1:0] area_idx;
  logic                 int_hit;
  logic [N_AREAS-1:0]   area_onehot;
  logic [N_AREAS-1:0]   dir_q;
  logic [N_DRAM-1:0]    dram_q;

  acs_area_decode #(
    .ADDR_W(ADDR_W), .AREA_BITS(AREA_BITS),
    .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE),
    .IO_BASE(IO_BASE), .IO_SIZE(IO_SIZE)
  ) u_decode (
    .addr(addr), .ram_en(ram_en),
    .area_idx(area_idx), .int_hit(int_hit), .area_onehot(area_onehot)
  );

  acs_cfg_regs #(.N_AREAS(N_AREAS), .N_DRAM(N_DRAM)) u_cfg (
    .clk(clk), .rst_n(rst_n), .mode_rom_en(mode_rom_en),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dir_q(dir_q), .dram_q(dram_q)
  );

  acs_select_out #(.N_AREAS(N_AREAS), .DRAM_LO(DRAM_LO), .N_DRAM(N_DRAM)) u_out (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .int_hit(int_hit),
    .area_onehot(area_onehot), .dram_q(dram_q),
    .cs_n(cs_n), .ras_n(ras_n)
  );

  assign cs_oe = dir_q;

endmodule

// File: rtl/acs_checker.sv
module acs_checker #(
  parameter int AREA_BITS = 3,
  parameter int N_AREAS   = 8,
  parameter int DRAM_LO   = 2,
  parameter int N_DRAM    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_valid,
  input logic                 int_hit,
  input logic [AREA_BITS-1:0] area_idx,
  input logic                 cfg_we,
  input logic                 cfg_sel,
  input logic [N_AREAS-1:0]   cfg_wdata,
  input logic [N_AREAS-1:0]   cs_n,
  input logic [N_AREAS-1:0]   cs_oe,
  input logic [N_DRAM-1:0]    ras_n
);

  logic [AREA_BITS-1:0] area_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) area_d <= '0;
    else        area_d <= area_idx;
  end

  // R1
  area_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !int_hit) |=> (!cs_n[area_d] && $countones(~cs_n) == 1));

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (&cs_n));

  // R3
  one_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R4
  internal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && int_hit) |=> (&cs_n));

  // R8
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (cs_oe == $past(cfg_wdata)));

  // R9
  dram_write_keeps_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> $stable(cs_oe));

  for (genvar j = 0; j < N_DRAM; j++) begin : g_ras_chk
    // R10
    ras_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n[j] |-> !cs_n[DRAM_LO + j]);
  end

endmodule

bind area_chip_select acs_checker #(
  .AREA_BITS(AREA_BITS), .N_AREAS(N_AREAS), .DRAM_LO(DRAM_LO), .N_DRAM(N_DRAM)
) u_acs_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .int_hit(int_hit),
  .area_idx(area_idx), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .cs_n(cs_n), .cs_oe(cs_oe), .ras_n(ras_n)
);

// File: tb/area_chip_select_bench.sv
module area_chip_select_bench;

  localparam int TB_CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_rom_en = 1'b0;
  logic        ram_en = 1'b0;
  logic [23:0] addr = '0;
  logic        acc_valid = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cs_n;
  logic [7:0]  cs_oe;
  logic [3:0]  ras_n;

  int n_tests = 0;
  int n_fail  = 0;
  logic [3:0] flags = '0;

  always #(TB_CLK_PERIOD/2) clk = ~clk;

  area_chip_select u_area_chip_select (
    .clk(clk), .rst_n(rst_n), .mode_rom_en(mode_rom_en), .ram_en(ram_en),
    .addr(addr), .acc_valid(acc_valid), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cs_n(cs_n), .cs_oe(cs_oe), .ras_n(ras_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent model: area is addr divided by 2 MB; windows by range compare.
  function automatic logic is_internal(input logic [23:0] a, input logic ram);
    if (a >= 24'hFFFF00) return 1'b1;
    if (ram && a >= 24'hFFB000 && a <= 24'hFFEFFF) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] exp_cs(input logic [23:0] a, input logic ram);
    int area;
    area = int'(a) / 32'h200000;
    if (is_internal(a, ram)) return 8'hFF;
    return ~(8'(1) << area);
  endfunction

  function automatic logic [3:0] exp_ras(input logic [23:0] a, input logic ram,
                                         input logic [3:0] f);
    logic [3:0] r;
    int area;
    area = int'(a) / 32'h200000;
    r = 4'hF;
    for (int j = 0; j < 4; j++)
      if (f[j] && area == j + 2 && !is_internal(a, ram)) r[j] = 1'b0;
    return r;
  endfunction

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; mode_rom_en = mode; acc_valid = 1'b0; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    flags = '0;
    @(negedge clk);
    check(mode ? "R7 dir reset" : "R6 dir reset", 32'(cs_oe), mode ? 32'h00 : 32'h01);
    check("R2 cs after reset", 32'(cs_n), 32'hFF);
    check("R10 ras after reset", 32'(ras_n), 32'hF);
  endtask

  task automatic access(input logic [23:0] a, input logic ram, input string req);
    addr = a; ram_en = ram; acc_valid = 1'b1;
    @(negedge clk);
    check(req, 32'(cs_n), 32'(exp_cs(a, ram)));
    check("R10 ras", 32'(ras_n), 32'(exp_ras(a, ram, flags)));
    check("R3 one low", 32'($countones(~cs_n) <= 1), 32'h1);
  endtask

  task automatic idle();
    acc_valid = 1'b0;
    @(negedge clk);
    check("R2 idle high", 32'(cs_n), 32'hFF);
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) flags = d[3:0];
  endtask

  initial begin
    logic [23:0] edges [7];
    edges[0] = 24'hFFAFFF; edges[1] = 24'hFFB000; edges[2] = 24'hFFEFFF;
    edges[3] = 24'hFFF000; edges[4] = 24'hFFFEFF; edges[5] = 24'hFFFF00;
    edges[6] = 24'hFFFFFF;

    for (int m = 0; m < 2; m++) begin
      do_reset(1'(m));
      for (int r = 0; r < 2; r++) begin
        for (int k = 0; k < 8; k++) begin
          logic [23:0] base;
          base = 24'(k * 32'h200000);
          access(base, 1'(r), "R1 area low edge");
          access(base + 24'd1, 1'(r), "R1 area low+1");
          access(base + 24'h1FFFFF, 1'(r), "R1 area high edge");
        end
        idle();
        for (int e = 0; e < 7; e++)
          access(edges[e], 1'(r), e >= 4 ? "R4 io window" : "R5 ram window");
        idle();
      end
    end

    // Direction writes (R8) and DRAM flag writes (R9, R10).
    cfg_write(1'b0, 8'hA5);
    check("R8 dir write", 32'(cs_oe), 32'hA5);
    cfg_write(1'b0, 8'h3C);
    check("R8 dir rewrite", 32'(cs_oe), 32'h3C);
    cfg_write(1'b1, 8'hF5);
    check("R9 dram write keeps oe", 32'(cs_oe), 32'h3C);
    for (int k = 0; k < 8; k++) access(24'(k * 32'h200000 + 32'h1234), 1'b1, "R9 flags 0101");
    cfg_write(1'b1, 8'h0A);
    for (int k = 2; k < 6; k++) access(24'(k * 32'h200000 + 32'h100), 1'b0, "R9 flags 1010");
    cfg_write(1'b1, 8'h0F);
    access(24'hBFFFFF, 1'b0, "R10 area5 top");
    access(24'hFFFF10, 1'b0, "R4 io with flags");
    idle();
    check("R10 ras idle", 32'(ras_n), 32'hF);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule